// File: doc/BRIEF.md
# Selectable Sampling Clock Generator

This block produces the bit-rate timing for a delta-modulation codec: one strobe for the encoder and one for the decoder, each exactly one reference cycle wide. It runs on a 1.024 MHz reference. A two-bit mode input selects the source. Three settings divide the reference internally, giving 64, 32 or 16 kbit/s. In those settings both data-clock ports are driven with the same divided clock, so circuits outside the block can lock to it.

The fourth setting (mode 00) turns both data-clock ports into inputs. The encoder and decoder clocks then come from outside and may run independently of each other, anywhere from 8 to 64 kbit/s. Each external clock is passed through a synchroniser, and each of its rising edges becomes one strobe in the reference domain.

A mode change takes effect at the next reference edge. At that edge the divider restarts, so the first period in the new mode is always complete.

Top module: `sample_clk_gen`

## Requirements
- R1: With mode 01 the encoder strobe repeats every 16 reference cycles. The driven port clock is high for 8 of those cycles.
- R2: With mode 10 the strobe period is 32 reference cycles, and the port clock is high for 16 of them.
- R3: With mode 11 the strobe period is 64 cycles, with 32 high cycles. While reset is low, the applied mode is 11 and the divider is at zero. In that state both ports are driven (direction outputs 1) with the clock high, and both strobes are 0.
- R4: In any internal mode, both direction outputs are 1. Both ports carry the same clock value, and the encoder and decoder strobes are identical.
- R5: In an internal mode the strobe is high in the first reference cycle of each high phase of the port clock, and only in that cycle.
- R6: A new mode value is applied at the next reference edge, and the divider restarts at that edge. While the mode input differs from the applied mode, no strobe is issued. The first strobe comes in the cycle right after the applied mode changes, and the next one comes one full new period later.
- R7: In mode 00 both direction outputs are 0 and both port drive values are 0.
- R8: In mode 00 every rising edge of an external clock input produces exactly one strobe. With two synchroniser stages, the strobe is high in the cycle after the second reference edge that follows the input change. Falling edges produce no strobe.
- R9: In mode 00 the encoder and decoder inputs are independent. Activity on one input never causes a strobe on the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.024 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 00 external, 01 divide by 16, 10 divide by 32, 11 divide by 64 |
| enc_clk_in | input | 1 | External encoder data clock (sampled in mode 00) |
| dec_clk_in | input | 1 | External decoder data clock (sampled in mode 00) |
| enc_bit_en | output | 1 | One-cycle encoder bit strobe |
| dec_bit_en | output | 1 | One-cycle decoder bit strobe |
| enc_clk_out | output | 1 | Drive value for the encoder data-clock port |
| dec_clk_out | output | 1 | Drive value for the decoder data-clock port |
| enc_clk_oe | output | 1 | Encoder data-clock port drive enable |
| dec_clk_oe | output | 1 | Decoder data-clock port drive enable |

## Verification
Each internal ratio is selected in turn, starting from a different previous mode each time. The first selection is timed so that the old divider would have fired in the same cycle as the change. This shows both the period and high-time of each ratio and the suppression of a stale strobe.

External mode is tested with clock pairs at the fastest and slowest rates, in both orders, and with one channel held idle. These runs tell a per-edge strobe apart from a level-based, doubled or cross-coupled one. A single isolated edge pins down the synchroniser latency and confirms that falling edges produce nothing.

// File: rtl/sample_clk_gen.sv
module sample_clk_gen #(
  parameter int DIV_FAST    = 16,
  parameter int DIV_MID     = 32,
  parameter int DIV_SLOW    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       enc_clk_in,
  input  logic       dec_clk_in,
  output logic       enc_bit_en,
  output logic       dec_bit_en,
  output logic       enc_clk_out,
  output logic       dec_clk_out,
  output logic       enc_clk_oe,
  output logic       dec_clk_oe
);
  localparam int         CNT_W    = $clog2(DIV_SLOW);
  localparam logic [1:0] MODE_EXT = 2'b00;
  localparam logic [1:0] MODE_RST = 2'b11;

  logic [1:0]       mode_q;
  logic [CNT_W-1:0] cnt, cnt_last, cnt_half;
  logic             settled, internal, int_clk, int_tick, gate;
  logic [1:0]       ext_pins, ext_rise;

  assign settled  = (mode_q == mode_sel);
  assign internal = (mode_q != MODE_EXT);

  always_comb begin
    case (mode_q)
      2'b01:   begin cnt_last = CNT_W'(DIV_FAST - 1); cnt_half = CNT_W'(DIV_FAST / 2); end
      2'b10:   begin cnt_last = CNT_W'(DIV_MID - 1);  cnt_half = CNT_W'(DIV_MID / 2);  end
      2'b11:   begin cnt_last = CNT_W'(DIV_SLOW - 1); cnt_half = CNT_W'(DIV_SLOW / 2); end
      default: begin cnt_last = '0;                   cnt_half = '0;                   end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      cnt    <= '0;
    end else if (!settled) begin
      mode_q <= mode_sel;
      cnt    <= '0;
    end else if (!internal || cnt == cnt_last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign int_clk  = internal && (cnt < cnt_half);
  assign int_tick = internal && (cnt == '0);

  assign ext_pins = {dec_clk_in, enc_clk_in};

  for (genvar i = 0; i < 2; i++) begin : g_sync
    logic [SYNC_STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], ext_pins[i]};
    end
    assign ext_rise[i] = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  end

  assign gate        = rst_n & settled;
  assign enc_bit_en  = gate & (internal ? int_tick : ext_rise[0]);
  assign dec_bit_en  = gate & (internal ? int_tick : ext_rise[1]);
  assign enc_clk_out = int_clk;
  assign dec_clk_out = int_clk;
  assign enc_clk_oe  = internal;
  assign dec_clk_oe  = internal;
endmodule

module sample_clk_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       enc_bit_en,
  input logic       dec_bit_en,
  input logic       enc_clk_out,
  input logic       dec_clk_out,
  input logic       enc_clk_oe,
  input logic       dec_clk_oe
);
  a_r4_ports_match: assert property (@(posedge clk) disable iff (!rst_n)
    enc_clk_oe |-> (dec_clk_oe && enc_clk_out == dec_clk_out && enc_bit_en == dec_bit_en));

  a_r5_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_clk_oe && $past(enc_clk_oe) && $rose(enc_clk_out) && $stable(mode_sel)) |-> enc_bit_en);

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    enc_bit_en |=> !enc_bit_en);

  a_r8_dec_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dec_bit_en |=> !dec_bit_en);

  a_r7_ext_released: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && $past(mode_sel) == 2'b00 && $past(rst_n)) |->
      (!enc_clk_oe && !dec_clk_oe && !enc_clk_out && !dec_clk_out));

  a_r4_int_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b00 && $past(mode_sel) == mode_sel && $past(rst_n)) |->
      (enc_clk_oe && dec_clk_oe));
endmodule

bind sample_clk_gen sample_clk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
  .enc_bit_en(enc_bit_en), .dec_bit_en(dec_bit_en),
  .enc_clk_out(enc_clk_out), .dec_clk_out(dec_clk_out),
  .enc_clk_oe(enc_clk_oe), .dec_clk_oe(dec_clk_oe)
);

// File: tb/sample_clk_gen_tb.sv
module sample_clk_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b11;
  logic       enc_clk_in = 1'b0, dec_clk_in = 1'b0;
  logic       enc_bit_en, dec_bit_en, enc_clk_out, dec_clk_out, enc_clk_oe, dec_clk_oe;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  sample_clk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .enc_clk_in(enc_clk_in), .dec_clk_in(dec_clk_in),
    .enc_bit_en(enc_bit_en), .dec_bit_en(dec_bit_en),
    .enc_clk_out(enc_clk_out), .dec_clk_out(dec_clk_out),
    .enc_clk_oe(enc_clk_oe), .dec_clk_oe(dec_clk_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input logic [1:0] m, input int n, input string tag);
    int bad;
    @(negedge clk);
    mode_sel = m;
    #1;
    chk(!enc_bit_en && !dec_bit_en, {tag, " R6 no strobe while mode pending"},
        {enc_bit_en, dec_bit_en}, 0);
    @(negedge clk);
    chk(enc_bit_en && enc_clk_out, {tag, " R6 first strobe after change"},
        {enc_bit_en, enc_clk_out}, 3);
    for (int p = 0; p < 2; p++) begin
      int high = 1;
      bad = 0;
      for (int k = 1; k <= n; k++) begin
        @(negedge clk);
        if (!enc_clk_oe || !dec_clk_oe || enc_clk_out != dec_clk_out ||
            enc_bit_en != dec_bit_en) bad++;
        if (k < n) begin
          high += int'(enc_clk_out);
          if (enc_bit_en) bad++;
        end
      end
      chk(enc_bit_en && enc_clk_out, {tag, " strobe period R5"}, enc_bit_en, 1);
      chk(high == n / 2, {tag, " high cycles per period"}, high, n / 2);
      chk(bad == 0, {tag, " R4 ports/strobes matched and no stray strobe"}, bad, 0);
    end
  endtask

  task automatic ext_run(input int pe, input int pd, input int t_len);
    int got_e = 0, got_d = 0, exp_e = 0, exp_d = 0, drv = 0;
    logic pv_e = 1'b0, pv_d = 1'b0;
    for (int t = 0; t < t_len; t++) begin
      logic ve, vd;
      @(negedge clk);
      got_e += int'(enc_bit_en);
      got_d += int'(dec_bit_en);
      if (enc_clk_oe || dec_clk_oe || enc_clk_out || dec_clk_out) drv++;
      ve = (pe > 0) ? ((t % pe) >= pe / 2) : 1'b0;
      vd = (pd > 0) ? ((t % pd) >= pd / 2) : 1'b0;
      if (ve && !pv_e) exp_e++;
      if (vd && !pv_d) exp_d++;
      pv_e = ve;
      pv_d = vd;
      enc_clk_in = ve;
      dec_clk_in = vd;
    end
    enc_clk_in = 1'b0;
    dec_clk_in = 1'b0;
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      got_e += int'(enc_bit_en);
      got_d += int'(dec_bit_en);
    end
    chk(got_e == exp_e, $sformatf("R8 enc strobes pe=%0d pd=%0d", pe, pd), got_e, exp_e);
    chk(got_d == exp_d, $sformatf("R9 dec strobes pe=%0d pd=%0d", pe, pd), got_d, exp_d);
    chk(drv == 0, "R7 ports released during run", drv, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!enc_bit_en && !dec_bit_en, "R3 reset strobes low", {enc_bit_en, dec_bit_en}, 0);
    chk(enc_clk_oe && dec_clk_oe && enc_clk_out && dec_clk_out, "R3 reset ports driven high",
        {enc_clk_oe, dec_clk_oe, enc_clk_out, dec_clk_out}, 15);
    rst_n = 1'b1;
    #1;
    chk(enc_bit_en && dec_bit_en, "R3 strobe at divider zero after reset", enc_bit_en, 1);
    // align: strobe at negedge now; wait 63 more so the old divider is about to fire
    repeat (64) @(negedge clk);
    chk(enc_bit_en, "R3 default mode period 64", enc_bit_en, 1);
    repeat (63) @(negedge clk);
    measure(2'b01, 16, "R1 div16");
    measure(2'b10, 32, "R2 div32");
    measure(2'b11, 64, "R3 div64");

    @(negedge clk);
    mode_sel = 2'b00;
    #1;
    chk(!enc_bit_en && !dec_bit_en, "R6 no strobe entering external", enc_bit_en, 0);
    repeat (4) @(negedge clk);
    chk(!enc_clk_oe && !dec_clk_oe && !enc_clk_out && !dec_clk_out, "R7 external ports released",
        {enc_clk_oe, dec_clk_oe, enc_clk_out, dec_clk_out}, 0);

    enc_clk_in = 1'b1;
    @(negedge clk);
    chk(!enc_bit_en, "R8 latency edge 1", enc_bit_en, 0);
    @(negedge clk);
    chk(enc_bit_en && !dec_bit_en, "R8 strobe after second edge", {enc_bit_en, dec_bit_en}, 2);
    @(negedge clk);
    chk(!enc_bit_en, "R8 strobe one cycle", enc_bit_en, 0);
    enc_clk_in = 1'b0;
    begin
      int seen = 0;
      for (int t = 0; t < 6; t++) begin
        @(negedge clk);
        seen += int'(enc_bit_en) + int'(dec_bit_en);
      end
      chk(seen == 0, "R8 falling edge gives no strobe", seen, 0);
    end

    ext_run(16, 128, 1024);
    ext_run(128, 16, 1024);
    ext_run(64, 32, 640);
    ext_run(16, 0, 512);
    ext_run(0, 20, 512);

    measure(2'b01, 16, "R6 ext to div16");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule